// File: doc/BRIEF.md
# Supply-Event Access Guard for Non-Volatile Memory

This block sits between a bank of supply monitors and the bus controller of a non-volatile memory. It receives three asynchronous level flags: the core supply is above its start level, the core supply is above its write-inhibit level, and the I/O supply is above its write-inhibit level. From these flags it decides when the memory may be accessed. While access is not allowed, it keeps both memory strobes (chip enable and write enable) parked high. It signals readiness only after a fixed startup interval has elapsed with the supplies good.

The block has two thresholds on the core supply, which gives it hysteresis. Leaving the inhibited condition needs the higher start level and then a full timed wait. Once ready, the block stays ready while the core supply sags below the start level, as long as it stays above its inhibit level. A drop of either supply below its inhibit level ends readiness at once. Recovery then needs a fresh start sequence.

If readiness is lost while the bus controller reports a cycle in flight, the block emits a one-cycle abort pulse together with the forced strobes.

Top module: `pwr_guard`

## Requirements
- R1: While rst_ni is low and right after its release, ready_o is 0, ce_hold_o and we_hold_o are 1, and abort_o is 0.
- R2: Each monitor flag passes through a two-flop synchronizer. A flag change driven between edges first affects ready_o on the third rising edge that follows it.
- R3: The block leaves the inhibited state only when start_lvl_i, core_ok_i and io_ok_i are all 1. If any of them is 0, ready_o stays 0 however long the wait.
- R4: ready_o rises exactly WAIT_CYCLES = (CLK_HZ/1e6)*STARTUP_US clock edges after the edge that enters the startup state.
- R5: If start_lvl_i drops during the startup wait, the count restarts from zero. ready_o then rises WAIT_CYCLES edges after the first edge that again sees the synchronized flag high.
- R6: Once ready_o is 1, a drop of start_lvl_i alone has no effect on ready_o.
- R7: While ready, core_ok_i going to 0 takes ready_o to 0.
- R8: While ready, io_ok_i going to 0 takes ready_o to 0.
- R9: ce_hold_o and we_hold_o are both 1 whenever ready_o is 0, and both are 0 whenever ready_o is 1.
- R10: abort_o is a single-cycle pulse, raised in the same cycle ready_o falls, and only if busy_i was 1 at that edge. If busy_i was 0, no pulse is given.
- R11: After a brownout, ready_o returns only after start_lvl_i is 1 again and a complete fresh WAIT_CYCLES interval has passed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_lvl_i | input | 1 | Core supply above start level (async) |
| core_ok_i | input | 1 | Core supply above write-inhibit level (async) |
| io_ok_i | input | 1 | I/O supply above write-inhibit level (async) |
| busy_i | input | 1 | Bus controller has a memory cycle in progress |
| ready_o | output | 1 | Memory access permitted |
| ce_hold_o | output | 1 | Force chip enable high |
| we_hold_o | output | 1 | Force write enable high |
| abort_o | output | 1 | One-cycle pulse: cycle cut short by loss of readiness |

## Verification
The hardest case to reach is a start-level dropout in the middle of the startup wait. The bench has to time this so that it lands after the startup state is entered but before the count completes. It must then tell a restarted count apart from a paused one. The bench raises the supplies and waits several cycles into the wait. It pulses start_lvl_i low for a few cycles, then expects ready_o low at the cycle a paused or uninterrupted count would have finished, and high exactly WAIT_CYCLES edges after the flag returns. A second awkward case is a brownout with busy_i held high. It is staged from the ready state so that the abort pulse and the falling ready_o can be checked in the same cycle.

// File: rtl/pwr_guard_pkg.sv
package pwr_guard_pkg;
  typedef enum logic [1:0] {
    GS_INHIBIT = 2'd0,
    GS_STARTUP = 2'd1,
    GS_READY   = 2'd2
  } guard_state_e;
endpackage

// File: rtl/pwr_guard_sync.sv
module pwr_guard_sync #(
  parameter int unsigned WIDTH  = 3,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [STAGES-1:0][WIDTH-1:0] stg_q;

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stg_q[s] <= '0;
      else if (s == 0) stg_q[s] <= d_i;
      else stg_q[s] <= stg_q[(s == 0) ? 0 : s-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/pwr_guard_timer.sv
module pwr_guard_timer #(
  parameter int unsigned LIMIT = 500000,
  localparam int unsigned CNT_W = $clog2(LIMIT + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  output logic             done_o,
  output logic [CNT_W-1:0] cnt_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else if (!run_i) cnt_q <= '0;
    else if (!done_o) cnt_q <= cnt_q + 1'b1;
  end

  assign done_o = run_i && (cnt_q == CNT_W'(LIMIT - 1));
  assign cnt_o  = cnt_q;
endmodule

// File: rtl/pwr_guard_fsm.sv
module pwr_guard_fsm
  import pwr_guard_pkg::*;
(
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         start_i,
  input  logic         inhibit_i,
  input  logic         done_i,
  input  logic         busy_i,
  output guard_state_e state_o,
  output logic         abort_o
);
  guard_state_e state_q, state_d;
  logic         abort_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      GS_INHIBIT: if (!inhibit_i && start_i) state_d = GS_STARTUP;
      GS_STARTUP: begin
        if (inhibit_i) state_d = GS_INHIBIT;
        else if (done_i) state_d = GS_READY;
      end
      GS_READY:   if (inhibit_i) state_d = GS_INHIBIT;
      default:    state_d = GS_INHIBIT;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= GS_INHIBIT;
      abort_q <= 1'b0;
    end else begin
      state_q <= state_d;
      abort_q <= (state_q == GS_READY) && inhibit_i && busy_i;
    end
  end

  assign state_o = state_q;
  assign abort_o = abort_q;
endmodule

// File: rtl/pwr_guard.sv
module pwr_guard
  import pwr_guard_pkg::*;
#(
  parameter int unsigned CLK_HZ      = 250_000_000,
  parameter int unsigned STARTUP_US  = 2000,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_lvl_i,
  input  logic core_ok_i,
  input  logic io_ok_i,
  input  logic busy_i,
  output logic ready_o,
  output logic ce_hold_o,
  output logic we_hold_o,
  output logic abort_o
);
  localparam int unsigned TICKS_US    = CLK_HZ / 1_000_000;
  localparam int unsigned WAIT_RAW    = TICKS_US * STARTUP_US;
  localparam int unsigned WAIT_CYCLES = (WAIT_RAW == 0) ? 1 : WAIT_RAW;
  localparam int unsigned CNT_W       = $clog2(WAIT_CYCLES + 1);

  logic [2:0]       flags_s;
  logic             start_s, core_s, io_s, inhibit, tmr_done;
  logic [CNT_W-1:0] tmr_cnt;
  guard_state_e     state;

  pwr_guard_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni,
    .d_i ({start_lvl_i, core_ok_i, io_ok_i}),
    .q_o (flags_s)
  );

  assign {start_s, core_s, io_s} = flags_s;
  assign inhibit = !core_s || !io_s;

  // count only while in startup with the start level present
  pwr_guard_timer #(.LIMIT(WAIT_CYCLES)) u_timer (
    .clk_i, .rst_ni,
    .run_i  ((state == GS_STARTUP) && start_s && !inhibit),
    .done_o (tmr_done),
    .cnt_o  (tmr_cnt)
  );

  pwr_guard_fsm u_fsm (
    .clk_i, .rst_ni,
    .start_i   (start_s),
    .inhibit_i (inhibit),
    .done_i    (tmr_done),
    .busy_i,
    .state_o   (state),
    .abort_o
  );

  assign ready_o   = (state == GS_READY);
  assign ce_hold_o = !ready_o;
  assign we_hold_o = (state != GS_READY);
endmodule

// File: rtl/pwr_guard_chk.sv
module pwr_guard_chk #(
  parameter int unsigned LIMIT = 1,
  parameter int unsigned CNT_W = 1
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             core_s,
  input logic             io_s,
  input logic [CNT_W-1:0] tmr_cnt,
  input logic             busy_i,
  input logic             ready_o,
  input logic             ce_hold_o,
  input logic             we_hold_o,
  input logic             abort_o
);
  // R1
  always_comb begin
    if (!rst_ni) begin
      reset_out_chk: assert (!ready_o && !abort_o);
    end
  end

  // R9
  hold_match_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ce_hold_o == !ready_o) && (we_hold_o == !ready_o));

  // R10
  abort_on_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_o |-> $fell(ready_o) && $past(busy_i));

  // R10
  abort_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_o |=> !abort_o);

  // R3
  ready_supply_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> $past(core_s && io_s));

  // R4
  full_wait_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ready_o) |-> $past(tmr_cnt) == CNT_W'(LIMIT - 1));
endmodule

bind pwr_guard pwr_guard_chk #(.LIMIT(WAIT_CYCLES), .CNT_W(CNT_W)) i_chk (
  .clk_i, .rst_ni, .core_s, .io_s, .tmr_cnt, .busy_i,
  .ready_o, .ce_hold_o, .we_hold_o, .abort_o
);

// File: tb/test_pwr_guard.sv
`timescale 1ns/1ps
module test_pwr_guard;
  localparam int L = 16;  // 2 MHz * 8 us

  logic clk = 1'b0, rst_ni = 1'b0;
  logic start_lvl = 1'b0, core_ok = 1'b0, io_ok = 1'b0, busy = 1'b0;
  logic ready, ce_hold, we_hold, abort_p;

  int cyc = 0, total = 0, bad = 0;
  bit finished = 0;

  typedef struct {
    int    at;
    logic  rdy;
    logic  abt;
    string tag;
  } exp_t;
  exp_t sb[$];

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  pwr_guard #(.CLK_HZ(2_000_000), .STARTUP_US(8)) i_pwr_guard (
    .clk_i(clk), .rst_ni, .start_lvl_i(start_lvl), .core_ok_i(core_ok),
    .io_ok_i(io_ok), .busy_i(busy), .ready_o(ready), .ce_hold_o(ce_hold),
    .we_hold_o(we_hold), .abort_o(abort_p)
  );

  task automatic push(int at, logic rdy, logic abt, string tag);
    exp_t e;
    e.at = at; e.rdy = rdy; e.abt = abt; e.tag = tag;
    sb.push_back(e);
  endtask

  task automatic wait_cyc(int n);
    while (cyc < n) @(negedge clk);
  endtask

  task automatic report(string tag, logic [1:0] act, logic [1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s cyc=%0d actual(rdy,abt/holds)=%b expected=%b", tag, cyc, act, exp);
    end
  endtask

  // monitor: pop due items, plus strobe-hold check each cycle
  initial begin
    forever begin
      @(negedge clk); #1;
      if (rst_ni) report("R9 holds", {ce_hold, we_hold}, {!ready, !ready});
      for (int i = sb.size() - 1; i >= 0; i--) begin
        if (sb[i].at == cyc) begin
          report(sb[i].tag, {ready, abort_p}, {sb[i].rdy, sb[i].abt});
          sb.delete(i);
        end
      end
    end
  end

  initial begin
    #(4 * 20000);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int c, d, e;
    repeat (3) @(negedge clk);
    report("R1 reset", {ready, abort_p}, 2'b00);
    report("R1 reset holds", {ce_hold, we_hold}, 2'b11);
    rst_ni = 1'b1;
    @(negedge clk);
    report("R1 after release", {ready, we_hold}, 2'b01);

    // R3: I/O supply missing, no progress
    start_lvl = 1; core_ok = 1; io_ok = 0;
    c = cyc;
    push(c + 40, 0, 0, "R3 io low blocks startup");
    wait_cyc(c + 41);

    // R4: full startup interval
    io_ok = 1; c = cyc;
    push(c + 2 + L, 0, 0, "R4 not yet ready");
    push(c + 3 + L, 1, 0, "R4 ready on time");
    wait_cyc(c + 5 + L);

    // R6: start level loss ignored when ready
    start_lvl = 0; c = cyc;
    push(c + 30, 1, 0, "R6 hysteresis keeps ready");
    wait_cyc(c + 31);

    // R7 + R10 + R2: core brownout with busy cycle
    busy = 1; core_ok = 0; c = cyc;
    push(c + 2, 1, 0, "R2 two-flop latency");
    push(c + 3, 0, 1, "R7 R10 abort on core brownout");
    push(c + 4, 0, 0, "R10 abort single pulse");
    wait_cyc(c + 6);

    // R11: recovery needs start level again and a fresh wait
    busy = 0; core_ok = 1; c = cyc;
    push(c + 40, 0, 0, "R11 no recovery without start level");
    wait_cyc(c + 41);
    start_lvl = 1; c = cyc;
    push(c + 2 + L, 0, 0, "R11 fresh wait not done");
    push(c + 3 + L, 1, 0, "R11 ready after fresh wait");
    wait_cyc(c + 5 + L);

    // R8 + R10: I/O brownout without busy, no abort
    io_ok = 0; c = cyc;
    push(c + 2, 1, 0, "R8 still ready");
    push(c + 3, 0, 0, "R8 R10 io brownout no abort");
    wait_cyc(c + 6);

    // R5: start drop mid-wait restarts the count
    io_ok = 1; c = cyc;
    wait_cyc(c + 8);
    start_lvl = 0; d = cyc;
    wait_cyc(d + 5);
    start_lvl = 1; e = cyc;
    push(c + 3 + L, 0, 0, "R5 original deadline passes");
    push(e + 1 + L, 0, 0, "R5 restarted not done");
    push(e + 2 + L, 1, 0, "R5 ready after restart");
    wait_cyc(e + 5 + L);

    if (sb.size() != 0) report("scoreboard drained", 2'(sb.size()), 2'b00);
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule